// File: doc/BRIEF.md
# Ethernet Header Parser with Next-Header Dispatch

This block takes a packet one byte per cycle, marked by start and end strobes, and walks a fixed parse graph over its leading headers. It first collects the destination address, source address and EtherType of the Ethernet header. It then branches on that type. A tag type leads into a 4-byte VLAN tag, whose inner type is branched on again with the same rules. An IPv4 or IPv6 type leads into a short state that captures the first 32-bit word of the network header and hands it on. Any other type ends the walk.

When the walk ends, the block raises a one-cycle done strobe. Together with it, the block presents the captured fields, one validity flag per header, a truncation flag and the byte offset where the data after the link-layer headers begins. A downstream stage uses the flags to decide which fields to read. It uses the offset to find the start of the network header or payload in its own copy of the packet.

Top module: `eth_hdr_parser`

## Requirements
- R1: After reset, out_done, out_trunc, all four header flags and out_pay_off are 0.
- R2: A byte is taken in each cycle with in_valid high. in_sop marks byte 0 of a packet and restarts parsing, even while a previous packet is still being parsed.
- R3: Packet bytes 0-5 form out_dst and bytes 6-11 form out_src, with the first byte in the most significant position. Bytes 12-13 form out_etype, also first byte most significant. out_eth_ok is set once byte 13 has been taken.
- R4: Type 16'h8100 leads into a 4-byte tag. Its first two bytes form out_tci and its last two form out_inner_etype, both big-endian, and out_vlan_ok is set. The inner type is dispatched by the same rules. A further 16'h8100 parses another tag, which overwrites both fields.
- R5: Type 16'h0800 makes the next 4 bytes form out_l3_word (big-endian) and sets out_ipv4_ok.
- R6: Type 16'h86DD makes the next 4 bytes form out_l3_word and sets out_ipv6_ok. out_ipv4_ok and out_ipv6_ok are never both set.
- R7: Any other type ends parsing on the byte that completes it. Only out_eth_ok and, if tags were parsed, out_vlan_ok are set, and out_trunc is 0.
- R8: out_pay_off reports 14 plus 4 for each complete tag. It is 0 when the Ethernet header itself is incomplete.
- R9: If in_eop arrives before parsing ends, the block reports done with out_trunc = 1. The flag of the unfinished header stays 0 and the flags of finished headers stay set. in_eop on the byte that ends parsing gives out_trunc = 0.
- R10: out_done is high for exactly one cycle, the cycle after the byte that ends parsing. The flags, out_trunc and out_pay_off then hold until the next in_sop. A field is meaningful when its header flag is set.
- R11: Bytes that arrive after parsing has ended and before the next in_sop, in_eop among them, produce no done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sop | input | 1 | First byte of a packet (with in_valid) |
| in_eop | input | 1 | Last byte of a packet (with in_valid) |
| in_data | input | 8 | Packet byte |
| out_done | output | 1 | One-cycle strobe: parse result ready |
| out_dst | output | 48 | Destination address |
| out_src | output | 48 | Source address |
| out_etype | output | 16 | Outer EtherType |
| out_tci | output | 16 | Tag control word of the last tag |
| out_inner_etype | output | 16 | Type carried in the last tag |
| out_l3_word | output | 32 | First 32 bits of the IPv4/IPv6 header |
| out_eth_ok | output | 1 | Ethernet header complete |
| out_vlan_ok | output | 1 | At least one tag complete |
| out_ipv4_ok | output | 1 | IPv4 first word captured |
| out_ipv6_ok | output | 1 | IPv6 first word captured |
| out_trunc | output | 1 | Packet ended before parsing finished |
| out_pay_off | output | OFF_W | Byte offset after the link-layer headers |

## Verification
The assertions assume that in_sop and in_eop are only meaningful while in_valid is high. They also assume that a packet carries few enough tags for its offset to fit in OFF_W bits. The stimulus raises the strobes only on valid bytes and never stacks more than two tags. Idle gaps of random length sit between bytes and between packets. Deliberate protocol abuses, such as a start marker arriving in the middle of a packet and stray bytes arriving between packets, are still legal under those assumptions and are driven on purpose.

// File: rtl/ehp_pkg.sv
package ehp_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ETH,
    PS_TAG,
    PS_V4,
    PS_V6
  } pstate_e;

  localparam int ETH_LEN = 14;
  localparam int TAG_LEN = 4;
  localparam int L3_PEEK = 4;
endpackage

// File: rtl/ehp_type_decode.sv
module ehp_type_decode
  import ehp_pkg::*;
#(
  parameter logic [15:0] TYPE_TAG = 16'h8100,
  parameter logic [15:0] TYPE_V4  = 16'h0800,
  parameter logic [15:0] TYPE_V6  = 16'h86DD
) (
  input  logic [15:0] etype,
  output pstate_e     nxt
);
  always_comb begin
    if (etype == TYPE_TAG)      nxt = PS_TAG;
    else if (etype == TYPE_V4)  nxt = PS_V4;
    else if (etype == TYPE_V6)  nxt = PS_V6;
    else                        nxt = PS_IDLE;
  end
endmodule

// File: rtl/ehp_field_cap.sv
module ehp_field_cap #(
  parameter int NBYTES = 2,
  localparam int W = 8 * NBYTES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);
  generate
    if (NBYTES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= din;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-9:0], din};
      end
    end
  endgenerate
endmodule

// File: rtl/eth_hdr_parser.sv
module eth_hdr_parser
  import ehp_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  output logic             out_done,
  output logic [47:0]      out_dst,
  output logic [47:0]      out_src,
  output logic [15:0]      out_etype,
  output logic [15:0]      out_tci,
  output logic [15:0]      out_inner_etype,
  output logic [31:0]      out_l3_word,
  output logic             out_eth_ok,
  output logic             out_vlan_ok,
  output logic             out_ipv4_ok,
  output logic             out_ipv6_ok,
  output logic             out_trunc,
  output logic [OFF_W-1:0] out_pay_off
);
  localparam int CNT_W = $clog2(ETH_LEN);
  localparam logic [CNT_W-1:0] IX_SRC      = CNT_W'(6);
  localparam logic [CNT_W-1:0] IX_TYPE     = CNT_W'(12);
  localparam logic [CNT_W-1:0] IX_ETH_LAST = CNT_W'(ETH_LEN - 1);
  localparam logic [CNT_W-1:0] IX_TAG_TYPE = CNT_W'(2);
  localparam logic [CNT_W-1:0] IX_TAG_LAST = CNT_W'(TAG_LEN - 1);
  localparam logic [CNT_W-1:0] IX_L3_LAST  = CNT_W'(L3_PEEK - 1);

  // state registers
  pstate_e          st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [OFF_W-1:0] boff_q, boff_d;
  logic [OFF_W-1:0] poff_q, poff_d;
  logic             done_q, done_d;
  logic             trunc_q, trunc_d;
  logic             eth_q, eth_d, tag_q, tag_d, v4_q, v4_d, v6_q, v6_d;

  // current byte context (a start marker overrides stored state)
  logic             take;
  pstate_e          cur_st;
  logic [CNT_W-1:0] cur_idx;
  logic [OFF_W-1:0] cur_off;
  logic             hdr_last;
  logic [15:0]      dec_in;
  pstate_e          dec_nxt;

  assign take    = in_valid && (in_sop || (st_q != PS_IDLE));
  assign cur_st  = in_sop ? PS_ETH : st_q;
  assign cur_idx = in_sop ? '0 : idx_q;
  assign cur_off = in_sop ? '0 : boff_q;

  // field capture enables
  logic en_dst, en_src, en_ety, en_tci, en_ity, en_l3;
  assign en_dst = take && (cur_st == PS_ETH) && (cur_idx < IX_SRC);
  assign en_src = take && (cur_st == PS_ETH) && (cur_idx >= IX_SRC) && (cur_idx < IX_TYPE);
  assign en_ety = take && (cur_st == PS_ETH) && (cur_idx >= IX_TYPE);
  assign en_tci = take && (cur_st == PS_TAG) && (cur_idx < IX_TAG_TYPE);
  assign en_ity = take && (cur_st == PS_TAG) && (cur_idx >= IX_TAG_TYPE);
  assign en_l3  = take && ((cur_st == PS_V4) || (cur_st == PS_V6));

  ehp_field_cap #(.NBYTES(6)) u_cap_dst (.clk(clk), .rst_n(rst_n), .en(en_dst), .din(in_data), .q(out_dst));
  ehp_field_cap #(.NBYTES(6)) u_cap_src (.clk(clk), .rst_n(rst_n), .en(en_src), .din(in_data), .q(out_src));
  ehp_field_cap #(.NBYTES(2)) u_cap_ety (.clk(clk), .rst_n(rst_n), .en(en_ety), .din(in_data), .q(out_etype));
  ehp_field_cap #(.NBYTES(2)) u_cap_tci (.clk(clk), .rst_n(rst_n), .en(en_tci), .din(in_data), .q(out_tci));
  ehp_field_cap #(.NBYTES(2)) u_cap_ity (.clk(clk), .rst_n(rst_n), .en(en_ity), .din(in_data), .q(out_inner_etype));
  ehp_field_cap #(.NBYTES(L3_PEEK)) u_cap_l3 (.clk(clk), .rst_n(rst_n), .en(en_l3), .din(in_data), .q(out_l3_word));

  // the low byte of each type register holds the first type byte already
  assign dec_in = (cur_st == PS_TAG) ? {out_inner_etype[7:0], in_data}
                                     : {out_etype[7:0], in_data};

  ehp_type_decode u_dec (.etype(dec_in), .nxt(dec_nxt));

  always_comb begin
    case (cur_st)
      PS_ETH:       hdr_last = (cur_idx == IX_ETH_LAST);
      PS_TAG:       hdr_last = (cur_idx == IX_TAG_LAST);
      PS_V4, PS_V6: hdr_last = (cur_idx == IX_L3_LAST);
      default:      hdr_last = 1'b0;
    endcase
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    boff_d  = boff_q;
    poff_d  = poff_q;
    trunc_d = trunc_q;
    eth_d   = eth_q;
    tag_d   = tag_q;
    v4_d    = v4_q;
    v6_d    = v6_q;
    done_d  = 1'b0;
    if (take) begin
      boff_d = cur_off + OFF_W'(1);
      if (in_sop) begin
        poff_d  = '0;
        trunc_d = 1'b0;
        eth_d   = 1'b0;
        tag_d   = 1'b0;
        v4_d    = 1'b0;
        v6_d    = 1'b0;
      end
      if (!hdr_last) begin
        idx_d = cur_idx + CNT_W'(1);
        st_d  = cur_st;
      end else begin
        idx_d = '0;
        case (cur_st)
          PS_ETH: begin
            eth_d  = 1'b1;
            poff_d = cur_off + OFF_W'(1);
            st_d   = dec_nxt;
          end
          PS_TAG: begin
            tag_d  = 1'b1;
            poff_d = cur_off + OFF_W'(1);
            st_d   = dec_nxt;
          end
          PS_V4: begin
            v4_d = 1'b1;
            st_d = PS_IDLE;
          end
          PS_V6: begin
            v6_d = 1'b1;
            st_d = PS_IDLE;
          end
          default: st_d = PS_IDLE;
        endcase
      end
      if (st_d == PS_IDLE) begin
        done_d = 1'b1;
      end else if (in_eop) begin
        done_d  = 1'b1;
        trunc_d = 1'b1;
        st_d    = PS_IDLE;
        idx_d   = '0;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      idx_q   <= '0;
      boff_q  <= '0;
      poff_q  <= '0;
      done_q  <= 1'b0;
      trunc_q <= 1'b0;
      eth_q   <= 1'b0;
      tag_q   <= 1'b0;
      v4_q    <= 1'b0;
      v6_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      boff_q  <= boff_d;
      poff_q  <= poff_d;
      done_q  <= done_d;
      trunc_q <= trunc_d;
      eth_q   <= eth_d;
      tag_q   <= tag_d;
      v4_q    <= v4_d;
      v6_q    <= v6_d;
    end
  end

  assign out_done    = done_q;
  assign out_trunc   = trunc_q;
  assign out_eth_ok  = eth_q;
  assign out_vlan_ok = tag_q;
  assign out_ipv4_ok = v4_q;
  assign out_ipv6_ok = v6_q;
  assign out_pay_off = poff_q;

  // R6
  ip_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ipv4_ok && out_ipv6_ok));

  // R3
  inner_needs_eth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vlan_ok || out_ipv4_ok || out_ipv6_ok) |-> out_eth_ok);

  // R8
  pay_off_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_trunc) |-> (out_pay_off >= OFF_W'(ETH_LEN)));

  // R8
  pay_off_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_vlan_ok) |-> (out_pay_off >= OFF_W'(ETH_LEN + TAG_LEN)));

  // R2
  sop_not_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !in_eop) |=> !out_done);

  // R11
  stray_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_IDLE && !(in_valid && in_sop)) |=> !out_done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !(in_valid && in_sop)) |=> !out_done);

  // R9
  trunc_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_trunc) |-> out_done);
endmodule

// File: tb/eth_hdr_parser_tb.sv
module eth_hdr_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 8;

  logic clk, rst_n;
  logic in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic out_done, out_eth_ok, out_vlan_ok, out_ipv4_ok, out_ipv6_ok, out_trunc;
  logic [47:0] out_dst, out_src;
  logic [15:0] out_etype, out_tci, out_inner_etype;
  logic [31:0] out_l3_word;
  logic [OFF_W-1:0] out_pay_off;

  eth_hdr_parser #(.OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .out_done(out_done), .out_dst(out_dst), .out_src(out_src),
    .out_etype(out_etype), .out_tci(out_tci), .out_inner_etype(out_inner_etype),
    .out_l3_word(out_l3_word), .out_eth_ok(out_eth_ok), .out_vlan_ok(out_vlan_ok),
    .out_ipv4_ok(out_ipv4_ok), .out_ipv6_ok(out_ipv6_ok), .out_trunc(out_trunc),
    .out_pay_off(out_pay_off));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  bit [7:0] pq[$];
  bit [7:0] tx[$];
  bit m_act = 0;
  bit m_eth, m_vlan, m_v4, m_v6;
  int m_off;
  bit [47:0] m_dst, m_src;
  bit [15:0] m_ety, m_tci, m_ity;
  bit [31:0] m_l3;
  bit e_done = 0, e_hold = 0;
  bit e_eth, e_vlan, e_v4, e_v6, e_trunc;
  int e_off;
  bit [47:0] e_dst, e_src;
  bit [15:0] e_ety, e_tci, e_ity;
  bit [31:0] e_l3;
  bit [31:0] rs = 32'h1234_5678;

  function automatic int rnd(int m);
    rs = rs * 32'd1664525 + 32'd1013904223;
    return int'(rs[30:8]) % m;
  endfunction

  // walks the byte queue behaviourally; returns 1 when the walk is complete
  function automatic bit parse_q();
    int n = pq.size();
    int p;
    bit [15:0] t;
    m_eth = 0; m_vlan = 0; m_v4 = 0; m_v6 = 0; m_off = 0;
    if (n < 14) return 0;
    for (int i = 0; i < 6; i++) m_dst = {m_dst[39:0], pq[i]};
    for (int i = 6; i < 12; i++) m_src = {m_src[39:0], pq[i]};
    m_ety = {pq[12], pq[13]};
    m_eth = 1; m_off = 14; p = 14; t = m_ety;
    while (t == 16'h8100) begin
      if (n < p + 4) return 0;
      m_tci = {pq[p], pq[p+1]};
      m_ity = {pq[p+2], pq[p+3]};
      m_vlan = 1; p += 4; m_off = p; t = m_ity;
    end
    if (t == 16'h0800 || t == 16'h86DD) begin
      if (n < p + 4) return 0;
      m_l3 = {pq[p], pq[p+1], pq[p+2], pq[p+3]};
      if (t == 16'h0800) m_v4 = 1; else m_v6 = 1;
    end
    return 1;
  endfunction

  task automatic compare();
    check("R10 done strobe", out_done, e_done);
    if (e_done || e_hold) begin
      check("R3 eth flag", out_eth_ok, e_eth);
      check("R4 vlan flag", out_vlan_ok, e_vlan);
      check("R5 ipv4 flag", out_ipv4_ok, e_v4);
      check("R6 ipv6 flag", out_ipv6_ok, e_v6);
      check("R9 trunc flag", out_trunc, e_trunc);
      check("R8 payload offset", out_pay_off, e_off[OFF_W-1:0]);
    end
    if (e_done) begin
      if (e_eth) begin
        check("R3 dst", out_dst, e_dst);
        check("R3 src", out_src, e_src);
        check("R3 etype", out_etype, e_ety);
      end
      if (e_vlan) begin
        check("R4 tci", out_tci, e_tci);
        check("R4 inner etype", out_inner_etype, e_ity);
      end
      if (e_v4 || e_v6) check("R5 R6 l3 word", out_l3_word, e_l3);
    end
  endtask

  task automatic cycle(bit v, bit s, bit e, bit [7:0] d);
    bit fin;
    @(negedge clk);
    compare();
    in_valid = v; in_sop = s; in_eop = e; in_data = d;
    e_done = 0;
    if (v) begin
      if (s) begin pq.delete(); m_act = 1; e_hold = 0; end
      if (m_act) begin
        pq.push_back(d);
        fin = parse_q();
        if (fin || e) begin
          e_done = 1; e_hold = 1; e_trunc = !fin; m_act = 0;
          e_eth = m_eth; e_vlan = m_vlan; e_v4 = m_v4; e_v6 = m_v6; e_off = m_off;
          e_dst = m_dst; e_src = m_src; e_ety = m_ety; e_tci = m_tci; e_ity = m_ity; e_l3 = m_l3;
        end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 8'h00);
  endtask

  task automatic send(bit gaps, bit with_eop);
    for (int i = 0; i < tx.size(); i++) begin
      if (gaps && rnd(3) == 0) idle(1 + rnd(2));
      cycle(1, i == 0, with_eop && (i == tx.size() - 1), tx[i]);
    end
  endtask

  task automatic put16(bit [15:0] w);
    tx.push_back(w[15:8]); tx.push_back(w[7:0]);
  endtask

  task automatic put_eth(bit [15:0] ety);
    tx.delete();
    for (int i = 0; i < 12; i++) tx.push_back(8'(rnd(256)));
    put16(ety);
  endtask

  task automatic put_bytes(int n);
    for (int i = 0; i < n; i++) tx.push_back(8'(rnd(256)));
  endtask

  initial begin
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 done", out_done, 0);
    check("R1 trunc", out_trunc, 0);
    check("R1 flags", {out_eth_ok, out_vlan_ok, out_ipv4_ok, out_ipv6_ok}, 0);
    check("R1 offset", out_pay_off, 0);
    rst_n = 1;
    idle(2);

    // R5 untagged IPv4 with gaps
    put_eth(16'h0800); put_bytes(20); send(1, 1); idle(2);
    // R6 untagged IPv6
    put_eth(16'h86DD); put_bytes(10); send(0, 1); idle(2);
    // R4 tag then IPv4
    put_eth(16'h8100); put16(16'hA00B); put16(16'h0800); put_bytes(8); send(1, 1); idle(1);
    // R4 R7 tag then unknown type
    put_eth(16'h8100); put16(16'h0123); put16(16'h88B5); put_bytes(5); send(0, 1); idle(1);
    // R4 two tags then IPv6
    put_eth(16'h8100); put16(16'h1111); put16(16'h8100); put16(16'h2222); put16(16'h86DD);
    put_bytes(6); send(1, 1); idle(2);
    // R7 unknown outer type, trailing bytes and eop ignored (R11)
    put_eth(16'h0806); put_bytes(12); send(0, 1); idle(1);
    // R9 R8 truncated inside Ethernet
    put_eth(16'h0800); tx = tx[0:4]; send(0, 1); idle(1);
    // R9 truncated inside tag
    put_eth(16'h8100); put16(16'h0001); send(0, 1); idle(1);
    // R9 eop on last type byte, IPv4 pending
    put_eth(16'h0800); send(0, 1); idle(1);
    // R9 eop exactly on completing byte of unknown type
    put_eth(16'h9000); send(0, 1); idle(1);
    // R11 stray bytes without sop, one with eop
    cycle(1, 0, 0, 8'h81); cycle(1, 0, 0, 8'h00); cycle(1, 0, 1, 8'h08); idle(2);
    // R2 restart: sop in the middle of a packet
    put_eth(16'h0800); tx = tx[0:8]; send(0, 0);
    put_eth(16'h86DD); put_bytes(4); send(0, 1); idle(1);
    // R9 single-byte packet followed at once by another
    cycle(1, 1, 1, 8'h55);
    put_eth(16'h0800); put_bytes(4); send(0, 1);
    put_eth(16'h0806); send(0, 1); idle(2);

    // random mix
    for (int k = 0; k < 60; k++) begin
      int kind = rnd(6);
      case (kind)
        0: begin put_eth(16'h0800); put_bytes(4); end
        1: begin put_eth(16'h86DD); put_bytes(4); end
        2: begin put_eth(16'h8100); put16(16'(rnd(65536))); put16(16'h0800); put_bytes(4); end
        3: begin put_eth(16'h8100); put16(16'(rnd(65536))); put16(16'h0842); end
        4: begin put_eth(16'h8100); put16(16'h0007); put16(16'h8100); put16(16'h0009);
                 put16(16'h86DD); put_bytes(4); end
        default: begin put_eth(16'(rnd(65536))); end
      endcase
      put_bytes(rnd(6));
      if (rnd(4) == 0) begin
        int cut = 1 + rnd(tx.size());
        while (tx.size() > cut) void'(tx.pop_back());
      end
      send(1, 1);
      idle(rnd(3));
    end
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule